// File: doc/BRIEF.md
# Battery Protection Fault Sequencer

This block watches a digitized cell voltage and a signed sense-resistor current code against programmable limits. It covers five hazards: cell overvoltage, cell undervoltage, overcurrent while discharging, overcurrent while charging, and a discharge short circuit. A hazard must hold without a break for its own programmable delay before its fault latches. The short-circuit delay is counted in microsecond ticks. The undervoltage and both overcurrent delays use millisecond ticks, and the overvoltage delay uses second ticks. All ticks come from one shared prescaler that runs off the system clock.

Latched faults drive two enables. The charge-path FET enable drops on overvoltage or charge overcurrent. The discharge-path FET enable drops on undervoltage, discharge overcurrent or short circuit. The voltage faults clear by themselves, but only after the cell has moved back past a hysteresis margin. The discharge current faults stay latched until a charger is present. The charge overcurrent fault clears once the charger is removed. A separate flag reports a deeply discharged cell, which calls for low-voltage charging.

Top module: `batt_guard_seq`

## Requirements
- R1: After reset `fault_flags` is 0, `chg_fet_en` and `dsg_fet_en` are 1, and `lv_chg` is 0 for a cell code of 1550 or above.
- R2: When `vcell_code >= ov_limit` holds for `ov_delay` second ticks, bit 0 of `fault_flags` sets and `chg_fet_en` goes to 0 while `dsg_fet_en` stays 1.
- R3: A latched overvoltage fault clears only once `vcell_code <= ov_limit - 215`.
- R4: When `vcell_code <= uv_limit` holds for `uv_delay` millisecond ticks, bit 1 sets and `dsg_fet_en` goes to 0 while `chg_fet_en` stays 1.
- R5: A latched undervoltage fault clears only once `vcell_code >= uv_limit + 105`.
- R6: When the discharge magnitude `-cur_code` is at least `ocd_limit` for `ocd_delay` millisecond ticks, bit 2 sets and `dsg_fet_en` goes to 0. A magnitude one below the limit never latches.
- R7: When `-cur_code >= scd_limit` holds for `scd_delay` microsecond ticks, bit 4 sets and `dsg_fet_en` goes to 0.
- R8: When `cur_code >= occ_limit` holds for `occ_delay` millisecond ticks, bit 3 sets and `chg_fet_en` goes to 0. The fault clears when `chg_present` is 0.
- R9: The discharge overcurrent and short-circuit faults stay latched after the current returns to zero. They clear only while `chg_present` is 1.
- R10: For a delay of D ticks with a tick period of P clocks, a fault is still clear (D-1)*P clocks after its condition starts and has latched D*P+2 clocks after it starts. D = 0 latches on the first clock edge.
- R11: If a condition drops for even one clock before its delay expires, the count restarts from zero.
- R12: `lv_chg` is 1 while `vcell_code < 1550` and 0 otherwise, one clock after the code changes.
- R13: The microsecond tick fires every `TICK_DIV` clocks, the millisecond tick on every `MS_DIV`-th microsecond tick, and the second tick on every `S_DIV`-th millisecond tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcell_code | input | V_W | Cell voltage code, 1 LSB = 1 mV |
| cur_code | input | I_W | Signed current code, positive while charging |
| chg_present | input | 1 | Charger attached flag |
| ov_limit | input | V_W | Overvoltage limit |
| uv_limit | input | V_W | Undervoltage limit |
| ocd_limit | input | I_W-1 | Discharge overcurrent magnitude limit |
| occ_limit | input | I_W-1 | Charge overcurrent limit |
| scd_limit | input | I_W-1 | Short-circuit magnitude limit |
| ov_delay | input | DLY_W | Overvoltage delay in second ticks |
| uv_delay | input | DLY_W | Undervoltage delay in millisecond ticks |
| ocd_delay | input | DLY_W | Discharge overcurrent delay in millisecond ticks |
| occ_delay | input | DLY_W | Charge overcurrent delay in millisecond ticks |
| scd_delay | input | DLY_W | Short-circuit delay in microsecond ticks |
| chg_fet_en | output | 1 | Charge-path FET enable |
| dsg_fet_en | output | 1 | Discharge-path FET enable |
| fault_flags | output | 5 | Latched faults: bit0 OV, bit1 UV, bit2 OCD, bit3 OCC, bit4 SCD |
| lv_chg | output | 1 | Low-voltage charging condition |

## Verification
The short-circuit delay is swept over every value from 0 to 6. At each value the bench probes both edges of the latch window, which pins down the microsecond base and the zero-delay case. Each of the other four detectors is driven with a condition held at its own base, so a detector wired to the wrong time base or the wrong FET shows up. The voltage tests step the cell through codes just inside and exactly on the release margins, which separates a correct hysteresis from a plain threshold. A condition that breaks for one clock and then resumes shows whether the count restarts. Currents held one code below each limit confirm that the comparisons are inclusive and that the sign of the current is handled correctly.

// File: rtl/batt_guard_pkg.sv
package batt_guard_pkg;
  localparam int unsigned NFLT = 5;
  localparam int unsigned F_OV  = 0;
  localparam int unsigned F_UV  = 1;
  localparam int unsigned F_OCD = 2;
  localparam int unsigned F_OCC = 3;
  localparam int unsigned F_SCD = 4;

  typedef enum logic [1:0] {BASE_US, BASE_MS, BASE_S} tbase_e;

  function automatic tbase_e base_of(input int unsigned idx);
    case (idx)
      F_OV:    return BASE_S;
      F_SCD:   return BASE_US;
      default: return BASE_MS;
    endcase
  endfunction
endpackage

// File: rtl/bg_timebase.sv
module bg_timebase #(
  parameter int unsigned TICK_DIV = 8,
  parameter int unsigned MS_DIV   = 1000,
  parameter int unsigned S_DIV    = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_us,
  output logic tick_ms,
  output logic tick_s
);
  localparam int unsigned US_W = $clog2(TICK_DIV);
  localparam int unsigned MS_W = $clog2(MS_DIV);
  localparam int unsigned S_W  = $clog2(S_DIV);

  logic [US_W-1:0] us_q, us_d;
  logic [MS_W-1:0] ms_q, ms_d;
  logic [S_W-1:0]  s_q,  s_d;

  always_comb begin
    tick_us = (us_q == US_W'(TICK_DIV - 1));
    tick_ms = tick_us && (ms_q == MS_W'(MS_DIV - 1));
    tick_s  = tick_ms && (s_q == S_W'(S_DIV - 1));
    us_d = tick_us ? '0 : us_q + 1'b1;
    ms_d = ms_q;
    if (tick_us) ms_d = tick_ms ? '0 : ms_q + 1'b1;
    s_d = s_q;
    if (tick_ms) s_d = tick_s ? '0 : s_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_q <= '0;
      ms_q <= '0;
      s_q  <= '0;
    end else begin
      us_q <= us_d;
      ms_q <= ms_d;
      s_q  <= s_d;
    end
  end

  assert_ms_nests_us_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tick_ms |-> tick_us);
  assert_s_nests_ms_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tick_s |-> tick_ms);
  assert_us_spacing_R13: assert property (@(posedge clk) disable iff (!rst_n)
    tick_us |=> !tick_us);
endmodule

// File: rtl/bg_fault_qual.sv
module bg_fault_qual #(
  parameter int unsigned DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trip,
  input  logic             rel,
  input  logic [DLY_W-1:0] dly,
  output logic             fault
);
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             flt_q, flt_d;

  always_comb begin
    cnt_d = cnt_q;
    flt_d = flt_q;
    if (flt_q) begin
      cnt_d = '0;
      if (rel) flt_d = 1'b0;
    end else if (!trip) begin
      cnt_d = '0;
    end else if (cnt_q >= dly) begin
      flt_d = 1'b1;
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      flt_q <= flt_d;
    end
  end

  assign fault = flt_q;

  assert_latch_needs_trip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_q) |-> $past(trip));
  assert_latch_after_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_q) |-> ($past(cnt_q) >= $past(dly)));
  assert_clear_needs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_q) |-> $past(rel));
endmodule

// File: rtl/batt_guard_seq.sv
module batt_guard_seq
  import batt_guard_pkg::*;
#(
  parameter int unsigned V_W      = 16,
  parameter int unsigned I_W      = 16,
  parameter int unsigned DLY_W    = 12,
  parameter int unsigned TICK_DIV = 8,
  parameter int unsigned MS_DIV   = 1000,
  parameter int unsigned S_DIV    = 1000,
  parameter int unsigned OV_HYST  = 215,
  parameter int unsigned UV_HYST  = 105,
  parameter int unsigned LV_LIMIT = 1550
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [V_W-1:0]       vcell_code,
  input  logic signed [I_W-1:0] cur_code,
  input  logic                 chg_present,
  input  logic [V_W-1:0]       ov_limit,
  input  logic [V_W-1:0]       uv_limit,
  input  logic [I_W-2:0]       ocd_limit,
  input  logic [I_W-2:0]       occ_limit,
  input  logic [I_W-2:0]       scd_limit,
  input  logic [DLY_W-1:0]     ov_delay,
  input  logic [DLY_W-1:0]     uv_delay,
  input  logic [DLY_W-1:0]     ocd_delay,
  input  logic [DLY_W-1:0]     occ_delay,
  input  logic [DLY_W-1:0]     scd_delay,
  output logic                 chg_fet_en,
  output logic                 dsg_fet_en,
  output logic [NFLT-1:0]      fault_flags,
  output logic                 lv_chg
);
  localparam int unsigned VX_W = V_W + 1;
  localparam int unsigned IX_W = I_W + 1;

  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic tick_us, tick_ms, tick_s;

  bg_timebase #(.TICK_DIV(TICK_DIV), .MS_DIV(MS_DIV), .S_DIV(S_DIV)) tb_i (
    .clk(clk), .rst_n(srst_n),
    .tick_us(tick_us), .tick_ms(tick_ms), .tick_s(tick_s)
  );

  logic signed [IX_W-1:0] cur_x, dis_x;
  logic [VX_W-1:0]        v_x;
  logic [NFLT-1:0]        trip, rel, flt;
  logic [DLY_W-1:0]       dly [NFLT];

  always_comb begin
    cur_x = {cur_code[I_W-1], cur_code};
    dis_x = -cur_x;
    v_x   = {1'b0, vcell_code};

    trip[F_OV]  = vcell_code >= ov_limit;
    trip[F_UV]  = vcell_code <= uv_limit;
    trip[F_OCD] = dis_x >= $signed({2'b00, ocd_limit});
    trip[F_SCD] = dis_x >= $signed({2'b00, scd_limit});
    trip[F_OCC] = cur_x >= $signed({2'b00, occ_limit});

    rel[F_OV]  = (v_x + VX_W'(OV_HYST)) <= {1'b0, ov_limit};
    rel[F_UV]  = v_x >= ({1'b0, uv_limit} + VX_W'(UV_HYST));
    rel[F_OCD] = chg_present;
    rel[F_SCD] = chg_present;
    rel[F_OCC] = !chg_present;

    dly[F_OV]  = ov_delay;
    dly[F_UV]  = uv_delay;
    dly[F_OCD] = ocd_delay;
    dly[F_OCC] = occ_delay;
    dly[F_SCD] = scd_delay;
  end

  for (genvar g = 0; g < NFLT; g++) begin : g_det
    logic tk;
    if (base_of(g) == BASE_US) begin : g_us
      assign tk = tick_us;
    end else if (base_of(g) == BASE_MS) begin : g_ms
      assign tk = tick_ms;
    end else begin : g_s
      assign tk = tick_s;
    end

    bg_fault_qual #(.DLY_W(DLY_W)) q_i (
      .clk(clk), .rst_n(srst_n), .tick(tk),
      .trip(trip[g]), .rel(rel[g]), .dly(dly[g]), .fault(flt[g])
    );
  end

  logic lv_q, lv_d;

  always_comb lv_d = vcell_code < V_W'(LV_LIMIT);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) lv_q <= 1'b0;
    else         lv_q <= lv_d;
  end

  assign fault_flags = flt;
  assign chg_fet_en  = !(flt[F_OV] || flt[F_OCC]);
  assign dsg_fet_en  = !(flt[F_UV] || flt[F_OCD] || flt[F_SCD]);
  assign lv_chg      = lv_q;

  assert_ov_clear_margin_R3: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(flt[F_OV]) |-> ($past(vcell_code) + V_W'(OV_HYST) <= $past(ov_limit)));
  assert_uv_clear_margin_R5: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(flt[F_UV]) |-> ($past(vcell_code) >= $past(uv_limit) + V_W'(UV_HYST)));
endmodule

// File: tb/batt_guard_seq_tb.sv
module batt_guard_seq_tb_top;
  localparam int TD = 2, MD = 3, SD = 2;
  localparam int P_US = TD, P_MS = TD * MD, P_S = TD * MD * SD;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] vcell, ovl, uvl;
  logic signed [15:0] cur;
  logic chg;
  logic [14:0] ocdl, occl, scdl;
  logic [11:0] ovd, uvd, ocdd, occd, scdd;
  logic chg_en, dsg_en, lv;
  logic [4:0] flags;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  batt_guard_seq #(.TICK_DIV(TD), .MS_DIV(MD), .S_DIV(SD)) dut_i (
    .clk(clk), .rst_n(rst_n), .vcell_code(vcell), .cur_code(cur),
    .chg_present(chg), .ov_limit(ovl), .uv_limit(uvl),
    .ocd_limit(ocdl), .occ_limit(occl), .scd_limit(scdl),
    .ov_delay(ovd), .uv_delay(uvd), .ocd_delay(ocdd),
    .occ_delay(occd), .scd_delay(scdd),
    .chg_fet_en(chg_en), .dsg_fet_en(dsg_en), .fault_flags(flags), .lv_chg(lv)
  );

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic state_chk(input string req, input logic [4:0] f);
    chk(req, {27'd0, flags}, {27'd0, f});
    chk(req, {31'd0, chg_en}, {31'd0, !(f[0] || f[3])});
    chk(req, {31'd0, dsg_en}, {31'd0, !(f[1] || f[2] || f[4])});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #5_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; vcell = 16'd3700; ovl = 16'd4200; uvl = 16'd2800;
    cur = '0; chg = 0; ocdl = 15'd500; occl = 15'd400; scdl = 15'd1500;
    ovd = 12'd3; uvd = 12'd4; ocdd = 12'd5; occd = 12'd2; scdd = 12'd0;
    waitn(3); rst_n = 1; waitn(4);
    // R1 reset state
    state_chk("R1", 5'b00000);
    chk("R1 lv", {31'd0, lv}, 32'd0);

    // R7 R10 short-circuit delay sweep in microsecond ticks
    ocdd = 12'd4095;
    for (int d = 0; d <= 6; d++) begin
      scdd = 12'(d);
      cur = -16'sd1600;
      if (d > 0) begin
        waitn((d - 1) * P_US);
        chk("R10 scd early", {31'd0, flags[4]}, 32'd0);
        waitn(d * P_US + 2 - (d - 1) * P_US);
      end else begin
        waitn(2);
      end
      state_chk("R7 R10 scd latched", 5'b10000);
      cur = '0; waitn(3);
      state_chk("R9 scd held", 5'b10000);
      chg = 1; waitn(2);
      state_chk("R9 scd cleared", 5'b00000);
      chg = 0; waitn(2);
    end

    // R6 boundary: one below the limit never latches
    ocdd = 12'd5;
    cur = -16'sd499; waitn(5 * P_MS + 10);
    state_chk("R6 below limit", 5'b00000);
    // R6 R10 exact limit latches within window
    cur = -16'sd500; waitn(4 * P_MS);
    state_chk("R10 ocd early", 5'b00000);
    waitn(P_MS + 2);
    state_chk("R6 ocd latched", 5'b00100);
    cur = '0; waitn(4);
    state_chk("R9 ocd held", 5'b00100);
    chg = 1; waitn(2); chg = 0; waitn(2);
    state_chk("R9 ocd cleared", 5'b00000);

    // R11 break of one clock restarts the count
    cur = -16'sd600; waitn(3 * P_MS);
    cur = '0; waitn(1);
    cur = -16'sd600; waitn(4 * P_MS);
    state_chk("R11 restart", 5'b00000);
    waitn(P_MS + 2);
    state_chk("R11 eventual latch", 5'b00100);
    cur = '0; chg = 1; waitn(2);

    // R8 charge overcurrent with charger attached
    cur = 16'sd399; waitn(2 * P_MS + 6);
    state_chk("R8 below limit", 5'b00000);
    cur = 16'sd450; waitn(P_MS);
    state_chk("R10 occ early", 5'b00000);
    waitn(P_MS + 2);
    state_chk("R8 occ latched", 5'b01000);
    cur = '0; waitn(3);
    state_chk("R8 occ held", 5'b01000);
    chg = 0; waitn(2);
    state_chk("R8 occ cleared", 5'b00000);

    // R2 R3 overvoltage in second ticks with release hysteresis
    vcell = 16'd4199; waitn(4 * P_S);
    state_chk("R2 below limit", 5'b00000);
    vcell = 16'd4200; waitn(2 * P_S);
    state_chk("R10 ov early", 5'b00000);
    waitn(P_S + 2);
    state_chk("R2 ov latched", 5'b00001);
    vcell = 16'd3986; waitn(3);
    state_chk("R3 ov held inside margin", 5'b00001);
    vcell = 16'd3985; waitn(2);
    state_chk("R3 ov released", 5'b00000);

    // R4 R5 undervoltage in millisecond ticks with release hysteresis
    vcell = 16'd2800; waitn(3 * P_MS);
    state_chk("R10 uv early", 5'b00000);
    waitn(P_MS + 2);
    state_chk("R4 uv latched", 5'b00010);
    vcell = 16'd2904; waitn(3);
    state_chk("R5 uv held inside margin", 5'b00010);
    vcell = 16'd2905; waitn(2);
    state_chk("R5 uv released", 5'b00000);

    // R12 low-voltage charging flag boundary
    uvd = 12'd4095;
    vcell = 16'd1550; waitn(2);
    chk("R12 at limit", {31'd0, lv}, 32'd0);
    vcell = 16'd1549; waitn(2);
    chk("R12 below limit", {31'd0, lv}, 32'd1);
    vcell = 16'd3700; waitn(2);
    chk("R12 recovered", {31'd0, lv}, 32'd0);
    state_chk("R4 uv not latched with long delay", 5'b00000);

    finish_run();
  end
endmodule